// File: doc/BRIEF.md
# Head-Visible Multi-FIFO Issue Queue

This block holds dispatched instructions waiting to issue. A fixed pool of entries is divided into several FIFOs of equal depth. Each FIFO takes new instructions at its tail and gives them up only from its head. Issue is therefore in order inside one FIFO, but out of order across the queue as a whole. Only a FIFO's head instruction can raise a request. A selector grants a bounded number of issue slots per cycle, and the lowest FIFO index wins.

A configuration input regroups the same pool. The options are many shallow FIFOs or fewer deep ones, and the product of FIFO count and depth always equals the pool size. A new grouping is adopted only once every FIFO is empty. Dispatch is held off until then.

A per-FIFO drain request stops new instructions from entering a FIFO so that it empties and can be shut down. For a dispatch steering unit, the block reports per-FIFO empty and full (cannot accept) flags, plus the tag most recently written at each tail.

Top module: `fifo_issue_queue`

## Requirements
- R1: After reset every FIFO is empty, no issue slot is valid, and the grouping code is 0.
- R2: A dispatch is accepted, and `dispAccept` is high in that cycle, only when all of the following hold: the target index is below the active FIFO count, the FIFO holds fewer entries than its depth, its drain request is low, and no regrouping is pending. An accepted entry becomes visible in the following cycle.
- R3: Within one FIFO, instructions issue in the order they were dispatched.
- R4: A FIFO requests issue only when it is active and non-empty and its head-ready bit is set. Ready bits of empty or inactive FIFOs have no effect, and entries behind a head never issue.
- R5: At most ISSUE_W FIFOs are granted per cycle, taken by ascending FIFO index. Slot s carries the s-th lowest granted FIFO's head tag. Unused slots have `issueValid` low. A granted head leaves at the clock edge.
- R6: Grouping code g means 16>>g FIFOs of depth 1<<g. Only codes 0..2 are legal. An illegal request code is ignored. A legal code that differs from the current one blocks dispatch, and it is adopted on the clock edge after a cycle in which the whole queue is empty.
- R7: While a FIFO's drain request is high, dispatch into it is refused. Its head still issues until the FIFO is empty.
- R8: `emptyVec[f]` is high when FIFO f holds nothing. `fullVec[f]` is high when FIFO f is inactive, draining, or at depth. For a non-empty FIFO, `tailTag` shows its newest entry.
- R9: A dispatch to a full FIFO is refused even if that FIFO's head issues in the same cycle. An entry dispatched into an empty FIFO cannot issue in the cycle it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| dispValid | input | 1 | dispatch attempt this cycle |
| dispFifo | input | 4 | target FIFO index |
| dispTag | input | TAG_W | producer tag of the dispatched instruction |
| dispAccept | output | 1 | dispatch accepted |
| headReady | input | 16 | per-FIFO readiness of the head instruction |
| drainReq | input | 16 | per-FIFO drain/shutdown request |
| cfgReq | input | 2 | requested grouping code |
| activeLog | output | 2 | grouping code in force |
| grantVec | output | 16 | FIFOs whose head issues this cycle |
| issueValid | output | ISSUE_W | slot valid flags |
| issueTag | output | ISSUE_W*TAG_W | slot tags, slot 0 in the low bits |
| emptyVec | output | 16 | per-FIFO empty flags |
| fullVec | output | 16 | per-FIFO cannot-accept flags |
| tailTag | output | 16*TAG_W | per-FIFO newest tag, FIFO 0 in the low bits |

## Verification
On every cycle, the assertions check that no FIFO is pushed past its depth or popped while empty, that no more than ISSUE_W grants are given, and that the grouping code never moves while any entry is held. The bench's scenarios are needed for everything else: that the grant choice follows FIFO index, that a FIFO's tags leave in dispatch order, that a pending regrouping holds dispatch until the pool empties, and that drain and illegal codes behave as stated. A cycle-accurate model in the bench predicts every output on every cycle.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
  localparam int ENT_LOG = 4;
  localparam int ENTRIES = 1 << ENT_LOG;
  localparam int MAX_LOG = 2;
  localparam int CFG_W = 2;
  localparam int CNT_W = ENT_LOG + 1;

  typedef struct packed {
    logic               push;
    logic [ENT_LOG-1:0] pushIdx;
    logic [ENTRIES-1:0] popVec;
    logic               apply;
    logic [CFG_W-1:0]   curLog;
  } iqCtl_t;
endpackage

// File: rtl/iq_datapath.sv
module iq_datapath
  import fiq_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  iqCtl_t                        ctl,
  input  logic [TAG_W-1:0]              pushTag,
  output logic [ENTRIES-1:0][TAG_W-1:0] headTag,
  output logic [ENTRIES-1:0][TAG_W-1:0] tailTagArr,
  output logic [ENTRIES-1:0]            emptyVec,
  output logic [ENTRIES-1:0]            atDepth
);
  logic [TAG_W-1:0]   pool    [ENTRIES];
  logic [ENT_LOG-1:0] headPtr [ENTRIES];
  logic [CNT_W-1:0]   fill    [ENTRIES];
  logic [ENT_LOG-1:0] ptrMask;
  logic [CNT_W-1:0]   depthCnt;
  logic [ENT_LOG-1:0] wrIdx;

  function automatic logic [ENT_LOG-1:0] slotOf(logic [ENT_LOG-1:0] fifo,
      logic [ENT_LOG-1:0] off, logic [CFG_W-1:0] lg, logic [ENT_LOG-1:0] msk);
    return (fifo << lg) | (off & msk);
  endfunction

  always_comb begin
    ptrMask  = ENT_LOG'((32'd1 << ctl.curLog) - 32'd1);
    depthCnt = CNT_W'(32'd1 << ctl.curLog);
    wrIdx    = slotOf(ctl.pushIdx,
                      headPtr[ctl.pushIdx] + fill[ctl.pushIdx][ENT_LOG-1:0],
                      ctl.curLog, ptrMask);
  end

  always_ff @(posedge clk) begin
    if (ctl.push) pool[wrIdx] <= pushTag;
  end

  for (genvar f = 0; f < ENTRIES; f++) begin : g_fifo
    logic pushHere;
    assign pushHere = ctl.push && (ctl.pushIdx == ENT_LOG'(f));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        headPtr[f] <= '0;
        fill[f]    <= '0;
      end else if (ctl.apply) begin
        headPtr[f] <= '0;
      end else begin
        if (ctl.popVec[f]) headPtr[f] <= (headPtr[f] + 1'b1) & ptrMask;
        case ({pushHere, ctl.popVec[f]})
          2'b10:   fill[f] <= fill[f] + 1'b1;
          2'b01:   fill[f] <= fill[f] - 1'b1;
          default: fill[f] <= fill[f];
        endcase
      end
    end

    always_comb begin
      emptyVec[f]   = (fill[f] == '0);
      atDepth[f]    = (fill[f] == depthCnt);
      headTag[f]    = pool[slotOf(ENT_LOG'(f), headPtr[f], ctl.curLog, ptrMask)];
      tailTagArr[f] = pool[slotOf(ENT_LOG'(f),
                           headPtr[f] + fill[f][ENT_LOG-1:0] - 1'b1,
                           ctl.curLog, ptrMask)];
    end

    // R4: a pop strobe only ever reaches a FIFO that holds an entry
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
      ctl.popVec[f] |-> (fill[f] != '0));
  end

  // R2: a push never lands in a FIFO already at its depth
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (fill[ctl.pushIdx] < depthCnt));
endmodule

// File: rtl/iq_control.sv
module iq_control
  import fiq_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int ISSUE_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          dispValid,
  input  logic [ENT_LOG-1:0]            dispFifo,
  input  logic [ENTRIES-1:0]            headReady,
  input  logic [ENTRIES-1:0]            drainReq,
  input  logic [CFG_W-1:0]              cfgReq,
  input  logic [ENTRIES-1:0]            emptyVec,
  input  logic [ENTRIES-1:0]            atDepth,
  input  logic [ENTRIES-1:0][TAG_W-1:0] headTag,
  output iqCtl_t                        ctl,
  output logic                          dispAccept,
  output logic [ENTRIES-1:0]            grantVec,
  output logic [ISSUE_W-1:0]            issueValid,
  output logic [ISSUE_W-1:0][TAG_W-1:0] issueTag,
  output logic [ENTRIES-1:0]            fullVec,
  output logic [CFG_W-1:0]              activeLog
);
  localparam int SLOT_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;

  logic [CFG_W-1:0]   curLog;
  logic [CNT_W-1:0]   fifoCount;
  logic [ENTRIES-1:0] activeMask;
  logic [ENTRIES-1:0] requestVec;
  logic               pending;
  logic [SLOT_W:0]    slotCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         curLog <= '0;
    else if (ctl.apply) curLog <= cfgReq;
  end

  always_comb begin
    fifoCount = CNT_W'(ENTRIES) >> curLog;
    for (int f = 0; f < ENTRIES; f++)
      activeMask[f] = (CNT_W'(f) < fifoCount);
    pending    = (cfgReq <= CFG_W'(MAX_LOG)) && (cfgReq != curLog);
    fullVec    = ~activeMask | atDepth | drainReq;
    dispAccept = dispValid && !fullVec[dispFifo] && !pending;
    requestVec = activeMask & headReady & ~emptyVec;
  end

  always_comb begin
    grantVec   = '0;
    issueValid = '0;
    issueTag   = '0;
    slotCnt    = '0;
    for (int f = 0; f < ENTRIES; f++) begin
      if (requestVec[f] && (slotCnt < (SLOT_W+1)'(ISSUE_W))) begin
        grantVec[f]                    = 1'b1;
        issueValid[slotCnt[SLOT_W-1:0]] = 1'b1;
        issueTag[slotCnt[SLOT_W-1:0]]   = headTag[f];
        slotCnt                        = slotCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.push    = dispAccept;
    ctl.pushIdx = dispFifo;
    ctl.popVec  = grantVec;
    ctl.apply   = pending && (&emptyVec);
    ctl.curLog  = curLog;
  end

  assign activeLog = curLog;

  // R5: never more grants than issue slots
  assert_grant_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantVec) <= ISSUE_W);

  // R6: the grouping is frozen while any FIFO still holds an entry
  assert_regroup_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(&emptyVec) |=> $stable(curLog));
endmodule

// File: rtl/fifo_issue_queue.sv
module fifo_issue_queue
  import fiq_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int ISSUE_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dispValid,
  input  logic [ENT_LOG-1:0]         dispFifo,
  input  logic [TAG_W-1:0]           dispTag,
  output logic                       dispAccept,
  input  logic [ENTRIES-1:0]         headReady,
  input  logic [ENTRIES-1:0]         drainReq,
  input  logic [CFG_W-1:0]           cfgReq,
  output logic [CFG_W-1:0]           activeLog,
  output logic [ENTRIES-1:0]         grantVec,
  output logic [ISSUE_W-1:0]         issueValid,
  output logic [ISSUE_W*TAG_W-1:0]   issueTag,
  output logic [ENTRIES-1:0]         emptyVec,
  output logic [ENTRIES-1:0]         fullVec,
  output logic [ENTRIES*TAG_W-1:0]   tailTag
);
  iqCtl_t                        ctl;
  logic [ENTRIES-1:0][TAG_W-1:0] headTag;
  logic [ENTRIES-1:0][TAG_W-1:0] tailTagArr;
  logic [ISSUE_W-1:0][TAG_W-1:0] issueTagArr;
  logic [ENTRIES-1:0]            atDepth;

  iq_control #(.TAG_W(TAG_W), .ISSUE_W(ISSUE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispFifo(dispFifo),
    .headReady(headReady), .drainReq(drainReq), .cfgReq(cfgReq),
    .emptyVec(emptyVec), .atDepth(atDepth), .headTag(headTag), .ctl(ctl),
    .dispAccept(dispAccept), .grantVec(grantVec), .issueValid(issueValid),
    .issueTag(issueTagArr), .fullVec(fullVec), .activeLog(activeLog)
  );

  iq_datapath #(.TAG_W(TAG_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pushTag(dispTag), .headTag(headTag),
    .tailTagArr(tailTagArr), .emptyVec(emptyVec), .atDepth(atDepth)
  );

  assign issueTag = issueTagArr;
  assign tailTag  = tailTagArr;
endmodule

// File: tb/fifo_issue_queue_bench.sv
module fifo_issue_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 6;
  localparam int IW = 4;
  localparam int NE = 16;

  logic            clk = 1'b0;
  logic            rstN;
  logic            dispValid;
  logic [3:0]      dispFifo;
  logic [TW-1:0]   dispTag;
  logic            dispAccept;
  logic [NE-1:0]   headReady, drainReq;
  logic [1:0]      cfgReq, activeLog;
  logic [NE-1:0]   grantVec, emptyVec, fullVec;
  logic [IW-1:0]   issueValid;
  logic [IW*TW-1:0] issueTag;
  logic [NE*TW-1:0] tailTag;

  int checks = 0;
  int errors = 0;
  int q[NE][$];
  int mLog = 0;
  int tagCtr = 1;
  bit done = 0;

  fifo_issue_queue #(.TAG_W(TW), .ISSUE_W(IW)) u_fifo_issue_queue (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispFifo(dispFifo),
    .dispTag(dispTag), .dispAccept(dispAccept), .headReady(headReady),
    .drainReq(drainReq), .cfgReq(cfgReq), .activeLog(activeLog),
    .grantVec(grantVec), .issueValid(issueValid), .issueTag(issueTag),
    .emptyVec(emptyVec), .fullVec(fullVec), .tailTag(tailTag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against the model, advance the model
  task automatic step(bit dv, int df, int hr, int dr, int cr);
    logic [NE-1:0] hrv, drv, eGrant, eEmpty, eFull;
    logic [IW-1:0] eValid;
    int eTag[IW];
    int nf, depth, n, dt;
    bit pend, allEmpty, acc;
    @(negedge clk);
    hrv = NE'(hr); drv = NE'(dr);
    dt = tagCtr % 64;
    dispValid = dv; dispFifo = 4'(df); dispTag = TW'(dt);
    headReady = hrv; drainReq = drv; cfgReq = 2'(cr);
    #1;
    nf = NE >> mLog; depth = 1 << mLog;
    pend = (cr <= 2) && (cr != mLog);
    allEmpty = 1;
    eGrant = '0; eValid = '0; n = 0;
    for (int s = 0; s < IW; s++) eTag[s] = 0;
    for (int f = 0; f < NE; f++) begin
      if (q[f].size() != 0) allEmpty = 0;
      eEmpty[f] = (q[f].size() == 0);
      eFull[f]  = (f >= nf) || (q[f].size() == depth) || drv[f];
      if (f < nf && q[f].size() > 0 && hrv[f] && n < IW) begin
        eGrant[f] = 1; eValid[n] = 1; eTag[n] = q[f][0]; n++;
      end
    end
    acc = dv && !eFull[df] && !pend;
    chk("R2", "dispAccept", dispAccept, acc);
    chk("R4/R5", "grantVec", grantVec, eGrant);
    chk("R5", "issueValid", issueValid, eValid);
    for (int s = 0; s < IW; s++)
      if (eValid[s]) chk("R3/R5", "issueTag", issueTag[s*TW +: TW], eTag[s]);
    chk("R8", "emptyVec", emptyVec, eEmpty);
    chk("R8", "fullVec", fullVec, eFull);
    for (int f = 0; f < NE; f++)
      if (q[f].size() > 0) chk("R8", "tailTag", tailTag[f*TW +: TW], q[f][$]);
    chk("R6", "activeLog", activeLog, mLog);
    for (int f = 0; f < NE; f++) if (eGrant[f]) void'(q[f].pop_front());
    if (acc) begin q[df].push_back(dt); tagCtr++; end
    if (pend && allEmpty) mLog = cr;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cfgNow;
    rstN = 0; dispValid = 0; dispFifo = 0; dispTag = 0;
    headReady = 0; drainReq = 0; cfgReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state
    chk("R1", "emptyVec", emptyVec, 16'hFFFF);
    chk("R1", "issueValid", issueValid, 0);
    chk("R1", "activeLog", activeLog, 0);

    // R5: sixteen depth-1 FIFOs, more ready heads than slots
    for (int f = 0; f < 8; f++) step(1, f, 0, 0, 0);
    step(1, 3, 0, 0, 0);                  // R9: full depth-1 FIFO refuses
    step(0, 0, 16'hFFFF, 0, 0);
    step(0, 0, 16'hFFFF, 0, 0);
    // R9: arrival into empty FIFO does not issue the same cycle
    step(1, 9, 16'hFFFF, 0, 0);
    step(0, 0, 16'hFFFF, 0, 0);
    // R4: ready bits for empty FIFOs only
    step(1, 2, 0, 0, 0);
    step(0, 0, 16'hFFFB, 0, 0);
    step(0, 0, 16'h0004, 0, 0);

    // R6: regroup to 4 FIFOs of 4 while occupied; dispatch blocked
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 5, 0, 0, 2);
    step(0, 0, 16'hFFFF, 0, 2);
    step(1, 4, 0, 0, 2);
    step(1, 4, 0, 0, 2);
    // R9/R3: fill FIFO 1, overfill, then issue in order
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 2);
    step(1, 6, 0, 0, 2);                  // inactive index refused
    step(1, 1, 16'h0002, 0, 2);           // full with same-cycle pop: refused
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0002, 0, 2);

    // R7: drain FIFO 2
    for (int i = 0; i < 3; i++) step(1, 2, 0, 0, 2);
    step(1, 2, 0, 16'h0004, 2);
    for (int i = 0; i < 4; i++) step(1, 2, 16'h0004, 16'h0004, 2);
    step(1, 2, 0, 0, 2);

    // R6: illegal code 3 ignored
    for (int i = 0; i < 4; i++) step(1, i, 16'h0001, 0, 3);
    for (int i = 0; i < 4; i++) step(0, 0, 16'hFFFF, 0, 3);
    step(0, 0, 16'hFFFF, 0, 1);
    step(0, 0, 16'hFFFF, 0, 1);

    // mixed traffic with occasional regrouping
    cfgNow = 1;
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 79) == 0) cfgNow = $urandom_range(0, 3);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15),
           $urandom_range(0, 65535),
           ($urandom_range(0, 9) == 0) ? (1 << $urandom_range(0, 15)) : 0,
           cfgNow);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule